// File: doc/BRIEF.md
# Eager Fork Control Unit

This block steers the handshake of one elastic channel out to several consumers. The producer side supplies a valid flag and receives a stall flag. Each of the N consumer branches receives a valid flag and returns a stall flag. Data paths are not handled here. Only the control signals are routed.

The fork is eager. A token that is valid at the root is offered at once to every branch that has not yet taken it, whatever the other branches are doing. Each branch has one pending flag, and that flag records whether the branch still owes acceptance of the current token. The root is held stalled while any pending branch stalls. When the root finally transfers, every flag is set again for the next token, so each branch sees every token exactly once.

Top module: `eager_fork`

## Requirements
- R1: A synchronous active-high reset sets every pending flag. After reset, a valid root with no branch stalled drives every branch valid high and the root stall low.
- R2: When root valid is low, every branch valid is low and root stall is low, whatever the branch stalls are.
- R3: Branch i valid is high exactly when root valid is high and branch i is still pending. This holds independently of the stalls of the other branches.
- R4: Root stall is high exactly when root valid is high and at least one pending branch has its stall high.
- R5: A branch that accepts a token while the root stays stalled does not see that token again. Its valid stays low until the root transfers.
- R6: In the cycle after a root transfer (root valid high, root stall low), every branch is pending again. A valid root then offers the new token to all branches.
- R7: While all branches stall on a fresh token, every branch valid stays high (retry, not idle) and root stall stays high.
- R8: For every branch, the number of transfers on that branch minus the number of root transfers is always 0 or 1.
- R9: A branch in retry (valid and stall both high) stays valid in the next cycle if root valid stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| root_valid | input | 1 | Token valid from the producer |
| root_stall | output | 1 | Stall returned to the producer |
| br_valid | output | N | Token valid offered to each branch |
| br_stall | input | N | Stall from each branch |

## Verification
The fork is driven with four input patterns, and each one separates eager behaviour from a wrong variant:
- All branches ready. This exposes any stray stall or missing reload between consecutive tokens.
- One branch stalled. This shows the early start of the ready branch, and shows that the branch is not offered the same token twice after it transfers.
- Every branch stalled. This separates retry from idle on the branch channels.
- Root idle with stalls high. This shows that no valid leaks out and no stall is reflected back.

Running token counts per branch against the root confirm the 0-or-1 difference across the whole sequence.

// File: rtl/eager_fork_pkg.sv
package eager_fork_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_XFER  = 2'd1,
    CH_RETRY = 2'd2
  } chan_state_e;

  function automatic chan_state_e chan_state(input logic v, input logic s);
    if (!v)     return CH_IDLE;
    else if (s) return CH_RETRY;
    else        return CH_XFER;
  endfunction

endpackage

// File: rtl/ef_branch_slot.sv
module ef_branch_slot (
  input  logic clk,
  input  logic rst,
  input  logic vl,
  input  logic sr,
  input  logic root_xfer,
  output logic vr,
  output logic hold
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)            pend_q <= 1'b1;
    else if (root_xfer) pend_q <= 1'b1;
    else if (vl && !sr) pend_q <= 1'b0;
  end

  assign vr   = vl & pend_q;
  assign hold = pend_q & sr;
endmodule

// File: rtl/ef_stall_merge.sv
module ef_stall_merge #(
  parameter int N = 2
) (
  input  logic         vl,
  input  logic [N-1:0] hold,
  output logic         sl
);
  assign sl = vl & (|hold);
endmodule

// File: rtl/eager_fork.sv
module eager_fork #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         root_valid,
  output logic         root_stall,
  output logic [N-1:0] br_valid,
  input  logic [N-1:0] br_stall
);
  logic [N-1:0] hold;
  logic         root_xfer;

  assign root_xfer = root_valid & ~root_stall;

  for (genvar i = 0; i < N; i++) begin : g_slot
    ef_branch_slot slot_i (
      .clk       (clk),
      .rst       (rst),
      .vl        (root_valid),
      .sr        (br_stall[i]),
      .root_xfer (root_xfer),
      .vr        (br_valid[i]),
      .hold      (hold[i])
    );
  end

  ef_stall_merge #(.N(N)) merge_i (
    .vl   (root_valid),
    .hold (hold),
    .sl   (root_stall)
  );
endmodule

// File: rtl/eager_fork_chk.sv
module eager_fork_chk #(
  parameter int N = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         root_valid,
  input logic         root_stall,
  input logic [N-1:0] br_valid,
  input logic [N-1:0] br_stall
);
  import eager_fork_pkg::*;

  chan_state_e root_st;
  assign root_st = chan_state(root_valid, root_stall);

  // R2: an idle root produces no valid and no stall
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !root_valid |-> (br_valid == '0 && !root_stall));

  // R4: a root stall is only raised while some branch stalls
  a_r4_stall_cause: assert property (@(posedge clk) disable iff (rst)
    root_stall |-> (root_valid && (|(br_valid & br_stall))));

  // R6: after a root transfer, every branch is pending again
  a_r6_reload: assert property (@(posedge clk) disable iff (rst)
    (root_st == CH_XFER) |=> (br_valid == {N{root_valid}}));

  for (genvar i = 0; i < N; i++) begin : g_br
    // R5: a branch that took the token while the root stayed held gets no repeat
    a_r5_no_repeat: assert property (@(posedge clk) disable iff (rst)
      (chan_state(br_valid[i], br_stall[i]) == CH_XFER && root_st == CH_RETRY)
        |=> !br_valid[i]);

    // R9: retry on a branch persists while the root stays valid
    a_r9_retry_holds: assert property (@(posedge clk) disable iff (rst)
      (chan_state(br_valid[i], br_stall[i]) == CH_RETRY) ##1 root_valid
        |-> br_valid[i]);

    // R8: branch transfers lead root transfers by at most one
    logic signed [3:0] lead_q;
    logic              bx;
    logic              rx;
    assign bx = br_valid[i] & ~br_stall[i];
    assign rx = root_valid & ~root_stall;
    always_ff @(posedge clk) begin
      if (rst) lead_q <= '0;
      else     lead_q <= lead_q + $signed({3'b0, bx}) - $signed({3'b0, rx});
    end
    a_r8_token_lead: assert property (@(posedge clk) disable iff (rst)
      (lead_q == 4'sd0 || lead_q == 4'sd1));
  end
endmodule

bind eager_fork eager_fork_chk #(.N(N)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .root_valid (root_valid),
  .root_stall (root_stall),
  .br_valid   (br_valid),
  .br_stall   (br_stall)
);

// File: tb/eager_fork_tb_top.sv
`timescale 1ns/1ps
module eager_fork_tb_top;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         root_valid = 1'b0;
  logic         root_stall;
  logic [N-1:0] br_valid;
  logic [N-1:0] br_stall = '0;

  int checks = 0;
  int errors = 0;
  int root_cnt = 0;
  int br_cnt [N];

  always #10 clk = ~clk;

  eager_fork #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .root_valid(root_valid), .root_stall(root_stall),
    .br_valid(br_valid), .br_stall(br_stall)
  );

  task automatic expect_out(input string req, input logic [N-1:0] ev, input logic es);
    checks++;
    if (br_valid !== ev || root_stall !== es) begin
      errors++;
      $display("FAIL %s: br_valid=%b root_stall=%b expected br_valid=%b root_stall=%b",
               req, br_valid, root_stall, ev, es);
    end
  endtask

  // drive at negedge, sample 5 ns later, then tally transfers before the posedge
  task automatic step(input logic v, input logic [N-1:0] s);
    @(negedge clk);
    root_valid = v;
    br_stall   = s;
    #5;
  endtask

  task automatic tally();
    if (!rst) begin
      if (root_valid && !root_stall) root_cnt++;
      for (int i = 0; i < N; i++)
        if (br_valid[i] && !br_stall[i]) br_cnt[i]++;
    end
  endtask

  always @(negedge clk) ;

  task automatic t_reset();
    rst = 1'b1;
    step(1'b0, '0); step(1'b0, '0);
    @(negedge clk); rst = 1'b0;
    root_valid = 1'b0; br_stall = '0; #5;
    expect_out("R2", 2'b00, 1'b0);
    step(1'b1, 2'b00);
    expect_out("R1", 2'b11, 1'b0); tally();
  endtask

  task automatic t_all_ready();
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 2'b00);
      expect_out("R6", 2'b11, 1'b0); tally();
    end
  endtask

  task automatic t_one_stalled();
    step(1'b1, 2'b01);
    expect_out("R3", 2'b11, 1'b1); tally();
    step(1'b1, 2'b01);
    expect_out("R5", 2'b01, 1'b1); tally();
    step(1'b1, 2'b10);
    expect_out("R5", 2'b01, 1'b0); tally();
    step(1'b1, 2'b00);
    expect_out("R6", 2'b11, 1'b0); tally();
    step(1'b1, 2'b10);
    expect_out("R4", 2'b11, 1'b1); tally();
    step(1'b1, 2'b00);
    expect_out("R4", 2'b10, 1'b0); tally();
  endtask

  task automatic t_all_stalled();
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 2'b11);
      expect_out("R7", 2'b11, 1'b1); tally();
    end
    step(1'b1, 2'b00);
    expect_out("R9", 2'b11, 1'b0); tally();
  endtask

  task automatic t_idle_stall();
    step(1'b0, 2'b11);
    expect_out("R2", 2'b00, 1'b0); tally();
    step(1'b1, 2'b00);
    expect_out("R2", 2'b11, 1'b0); tally();
  endtask

  task automatic t_counts();
    for (int i = 0; i < N; i++) begin
      checks++;
      if (br_cnt[i] - root_cnt < 0 || br_cnt[i] - root_cnt > 1) begin
        errors++;
        $display("FAIL R8: branch %0d count=%0d root count=%0d expected difference 0 or 1",
                 i, br_cnt[i], root_cnt);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) br_cnt[i] = 0;
    t_reset();
    t_all_ready();
    t_one_stalled();
    t_all_stalled();
    t_idle_stall();
    t_counts();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule